// File: doc/BRIEF.md
# Single-Slope Pixel Capture Sequencer

This block is the digital half of an in-pixel single-slope converter array. After a start pulse it runs a ramp window of exactly 2^CODE_W clock cycles. During that window one shared binary counter drives a Gray-coded bus. Every pixel keeps a CODE_W-bit code register that copies the bus on each ramp cycle. It stops copying once that pixel's comparator input has been seen tripped through a two-flop synchroniser. From then on the code stays frozen until the next frame starts, whatever the comparator does afterwards.

The read phase follows the ramp with no gap. Each row owns ROW_CYC cycles. In the first cycle of a row's slot, that row's codes go through one Gray-to-binary converter per column. The results are registered onto the column bus, and `out_valid` is raised for one cycle. One frame therefore lasts 2^CODE_W + ROWS*ROW_CYC cycles. A one-cycle `frame_done` marks its end and the return to idle.

The output stream carries a valid strobe and has no ready input. Row timing is fixed by the frame schedule, so the consumer cannot apply back-pressure. Each strobed word must be taken in the cycle in which `out_valid` is high.

Top module: `ssc_capture_seq`

## Requirements
- R1: During the ramp window, the Gray bus changes by exactly one bit from one clock to the next.
- R2: A start accepted at clock edge E0 gives a ramp window of 2^CODE_W cycles, then the read phase with no gap. `frame_done` goes high after edge E0+2^CODE_W+ROWS*ROW_CYC and stays high for exactly one cycle.
- R3: A comparator input raised just after edge E0+d, with 0 <= d <= 253, freezes that pixel at binary code d+1. This accounts for the two synchroniser flops.
- R4: A pixel whose comparator never trips in the window ends at code 255. A pixel already tripped when the frame starts reads 0.
- R5: Once a pixel is frozen, its code stays frozen for the rest of the frame even if the comparator input falls again.
- R6: Rows are read in ascending order. Row r's word appears with `out_valid` after edge E0+2^CODE_W+r*ROW_CYC+1, with `out_row`=r. Column c occupies `col_data[c*CODE_W +: CODE_W]`.
- R7: Output codes are binary: bit i is the XOR of stored Gray bits i through CODE_W-1, and bit 0 is the least significant bit.
- R8: A start pulse during the ramp or read phase is ignored. The frame timing and the number of output words do not change.
- R9: A synchronous reset in the middle of a frame returns the block to idle. That frame produces no further words and no `frame_done`.
- R10: After reset, `out_valid`, `frame_done` and `col_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame launch pulse, accepted only in idle |
| trip | input | ROWS*COLS | Per-pixel comparator state; bit r*COLS+c is row r, column c; 1 = tripped |
| out_valid | output | 1 | One-cycle strobe for each row word |
| out_row | output | clog2(ROWS) | Row index of the current word |
| col_data | output | COLS*CODE_W | Binary codes of the row, column c at bits c*CODE_W upward |
| frame_done | output | 1 | One-cycle pulse when the last row slot ends |

## Verification
The hardest thing to reach from the ports is the exact freeze point. Two synchroniser stages sit between the comparator pin and the write gate, so a trip is only meaningful counted from the accepted start edge. The stimulus counts falling edges from that start edge and raises each trip input at a chosen offset. The offsets cover the first cycles, mid-range codes where several Gray bits change together, the last two counts, never, and already tripped before the start. Some trips are single-cycle pulses, which checks that a falling comparator does not reopen tracking. Start pulses placed inside the ramp and the read slots, and a reset in the middle of a ramp, cover the ignored and aborted paths.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RAMP = 2'd1,
    SQ_READ = 2'd2
  } sq_state_t;
endpackage

// File: rtl/ssc_gray_counter.sv
module ssc_gray_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] gray,
  output logic         at_end
);
  logic [W-1:0] bin_q;

  always_ff @(posedge clk) begin
    if (rst || clr) bin_q <= '0;
    else if (run)   bin_q <= bin_q + 1'b1;
  end

  assign gray   = bin_q ^ (bin_q >> 1);
  assign at_end = &bin_q;
endmodule

// File: rtl/ssc_pixel.sv
module ssc_pixel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ramp,
  input  logic         trip,
  input  logic [W-1:0] gray_bus,
  output logic [W-1:0] code
);
  logic sync1_q, sync2_q, frozen_q;

  // two-flop synchroniser for the asynchronous comparator
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= trip;
      sync2_q <= sync1_q;
    end
  end

  // code follows the bus until the first synchronised trip, then holds
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code     <= '0;
      frozen_q <= 1'b0;
    end else if (ramp) begin
      if (sync2_q) frozen_q <= 1'b1;
      if (!sync2_q && !frozen_q) code <= gray_bus;
    end
  end
endmodule

// File: rtl/ssc_gray2bin.sv
module ssc_gray2bin #(
  parameter int W = 8
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end
endmodule

// File: rtl/ssc_capture_seq.sv
module ssc_capture_seq
  import ssc_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int ROWS    = 4,
  parameter int COLS    = 2,
  parameter int ROW_CYC = 4,
  localparam int PIX    = ROWS * COLS,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int WORD_W = COLS * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PIX-1:0]    trip,
  output logic              out_valid,
  output logic [ROW_W-1:0]  out_row,
  output logic [WORD_W-1:0] col_data,
  output logic              frame_done
);
  localparam int SLOT_W = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(ROW_CYC - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  sq_state_t         state_q;
  logic [ROW_W-1:0]  row_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CODE_W-1:0] gray_bus;
  logic              at_end;
  logic [PIX*CODE_W-1:0] codes_flat;
  logic [WORD_W-1:0] row_arr [ROWS];
  logic [WORD_W-1:0] row_sel;
  logic [WORD_W-1:0] bin_cols;

  logic launch, in_ramp;
  assign launch  = (state_q == SQ_IDLE) && start;
  assign in_ramp = (state_q == SQ_RAMP);

  ssc_gray_counter #(.W(CODE_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(launch), .run(in_ramp),
    .gray(gray_bus), .at_end(at_end)
  );

  for (genvar p = 0; p < PIX; p++) begin : g_pix
    ssc_pixel #(.W(CODE_W)) u_pix (
      .clk(clk), .rst(rst), .clr(launch), .ramp(in_ramp),
      .trip(trip[p]), .gray_bus(gray_bus),
      .code(codes_flat[p*CODE_W +: CODE_W])
    );
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_arr[r] = codes_flat[r*WORD_W +: WORD_W];
  end
  assign row_sel = row_arr[row_q];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    ssc_gray2bin #(.W(CODE_W)) u_g2b (
      .g(row_sel[c*CODE_W +: CODE_W]),
      .b(bin_cols[c*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      row_q      <= '0;
      slot_q     <= '0;
      out_valid  <= 1'b0;
      out_row    <= '0;
      col_data   <= '0;
      frame_done <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      frame_done <= 1'b0;
      case (state_q)
        SQ_IDLE: if (start) state_q <= SQ_RAMP;
        SQ_RAMP: if (at_end) begin
          state_q <= SQ_READ;
          row_q   <= '0;
          slot_q  <= '0;
        end
        SQ_READ: begin
          if (slot_q == '0) begin
            out_valid <= 1'b1;
            out_row   <= row_q;
            col_data  <= bin_cols;
          end
          if (slot_q == SLOT_LAST) begin
            slot_q <= '0;
            if (row_q == ROW_LAST) begin
              state_q    <= SQ_IDLE;
              row_q      <= '0;
              frame_done <= 1'b1;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssc_capture_chk.sv
module ssc_capture_chk
  import ssc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int PIX    = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input sq_state_t             state,
  input logic [CODE_W-1:0]     gray,
  input logic [PIX*CODE_W-1:0] codes,
  input logic                  out_valid,
  input logic                  frame_done
);
  // R1
  gray_one_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_RAMP && $past(state) == SQ_RAMP) |-> $countones(gray ^ $past(gray)) == 1);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R2
  done_in_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> state == SQ_IDLE);

  // R5
  codes_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_RAMP && !(state == SQ_IDLE && start)) |=> $stable(codes));

  // R6
  valid_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(state) == SQ_READ);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_RAMP && start) |=> state != SQ_IDLE);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (state == SQ_IDLE && !out_valid && !frame_done));
endmodule

bind ssc_capture_seq ssc_capture_chk #(.CODE_W(CODE_W), .PIX(PIX)) u_chk (
  .clk(clk), .rst(rst), .start(start), .state(state_q), .gray(gray_bus),
  .codes(codes_flat), .out_valid(out_valid), .frame_done(frame_done)
);

// File: tb/tb_ssc_capture_seq.sv
module tb_ssc_capture_seq;
  localparam int W = 8, ROWS = 4, COLS = 2, RC = 4, PIX = ROWS * COLS;
  localparam int RAMP = 256;
  localparam int DONE_OFS = RAMP + ROWS * RC;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PIX-1:0] trip = '0;
  logic out_valid, frame_done;
  logic [1:0] out_row;
  logic [COLS*W-1:0] col_data;

  ssc_capture_seq #(.CODE_W(W), .ROWS(ROWS), .COLS(COLS), .ROW_CYC(RC)) dut (
    .clk(clk), .rst(rst), .start(start), .trip(trip), .out_valid(out_valid),
    .out_row(out_row), .col_data(col_data), .frame_done(frame_done)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, e0 = 0;
  int done_cyc = -1, done_cnt = 0, valid_cnt = 0;
  int q_row[$], q_cyc[$];
  logic [COLS*W-1:0] q_data[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      valid_cnt++;
      if (q_row.size() == 0) begin
        check(1'b0, "R6 R8 R9 unexpected word", 1, 0);
      end else begin
        int er, ec;
        logic [COLS*W-1:0] ed;
        er = q_row.pop_front(); ec = q_cyc.pop_front(); ed = q_data.pop_front();
        check(int'(out_row) == er, "R6 row order", int'(out_row), er);
        check(cyc - e0 == ec, "R6 word timing", cyc - e0, ec);
        for (int c = 0; c < COLS; c++)
          check(col_data[c*W +: W] == ed[c*W +: W], "R3 R4 R5 R7 captured code",
                int'(col_data[c*W +: W]), int'(ed[c*W +: W]));
      end
    end
    if (!rst && frame_done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  function automatic int expect_code(input int d);
    if (d < 0) return 0;
    if (d + 1 > 255) return 255;
    return d + 1;
  endfunction

  // driver: push expected words, then run one frame
  task automatic run_frame(input int d[PIX], input bit pulse[PIX], input int restart_at);
    int dc0, vc0;
    trip = '0;
    for (int p = 0; p < PIX; p++) if (d[p] < 0) trip[p] = 1'b1;
    repeat (3) @(negedge clk);
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS*W-1:0] w;
      for (int c = 0; c < COLS; c++) w[c*W +: W] = W'(expect_code(d[r*COLS + c]));
      q_row.push_back(r); q_cyc.push_back(RAMP + r * RC + 1); q_data.push_back(w);
    end
    dc0 = done_cnt; vc0 = valid_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e0 = cyc;
    for (int c = 0; c < 300; c++) begin
      for (int p = 0; p < PIX; p++)
        if (d[p] >= 0) begin
          if (pulse[p]) trip[p] = (c == d[p]);
          else if (c >= d[p]) trip[p] = 1'b1;
        end
      start = (c == restart_at);
      @(negedge clk);
    end
    start = 1'b0;
    check(done_cnt - dc0 == 1, "R2 R8 one frame_done", done_cnt - dc0, 1);
    check(done_cyc - e0 == DONE_OFS, "R2 frame length", done_cyc - e0, DONE_OFS);
    check(valid_cnt - vc0 == ROWS, "R6 R8 word count", valid_cnt - vc0, ROWS);
    check(q_row.size() == 0, "R6 scoreboard drained", q_row.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    check(frame_done == 1'b0, "R10 frame_done after reset", int'(frame_done), 0);
    check(col_data == '0, "R10 col_data after reset", int'(col_data), 0);

    // frame 1: boundaries of the window (R3 R4)
    run_frame('{-2, 0, 1, 10, 100, 253, 254, 300},
              '{0, 0, 0, 0, 0, 0, 0, 0}, -1);
    // frame 2: mid codes, single-cycle trip pulses (R5), start in ramp (R8)
    run_frame('{5, 37, 128, 200, 63, 64, 127, 170},
              '{0, 1, 0, 1, 0, 1, 1, 0}, 100);
    // frame 3: start inside read phase (R8)
    run_frame('{2, 3, 4, 15, 31, -1, 191, 222},
              '{1, 0, 0, 0, 1, 0, 0, 0}, 262);

    // R9: reset in the middle of a ramp aborts the frame
    begin
      int dc0, vc0;
      dc0 = done_cnt; vc0 = valid_cnt;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (50) @(negedge clk);
      rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
      repeat (300) @(negedge clk);
      check(done_cnt == dc0, "R9 no frame_done after abort", done_cnt - dc0, 0);
      check(valid_cnt == vc0, "R9 no words after abort", valid_cnt - vc0, 0);
      check(col_data == '0, "R9 col_data cleared", int'(col_data), 0);
    end

    // frame after abort behaves normally
    run_frame('{0, 254, 7, 8, 9, 90, 160, 240},
              '{0, 0, 0, 0, 0, 0, 0, 0}, -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule